// File: doc/BRIEF.md
# Postfix Stack Expression Evaluator

This block evaluates integer arithmetic written in reverse Polish order. A producer feeds it a stream of tokens over a valid/ready handshake. Each token is either an operand, which goes onto an internal operand stack, or an operator. An operator takes its two inputs from the top of that stack and puts its single result back there. Operators carry no operand addresses. The value on top of the stack is always visible on the result port, so after the last token of an expression the answer can be read directly.

The stack has a fixed number of entries and a fixed word width. Arithmetic wraps at the word width. Two sticky error flags report misuse. One is set by an operator that finds too few entries on the stack. The other is set by an operand pushed onto a full stack. A clear input empties the stack and resets both flags without a full reset. Multiplication takes one extra cycle to write back. The block signals this by holding ready low for that cycle.

Top module: `rpn_eval`

## Requirements
- R1: An accepted token with kind code 0 pushes `tok_data` onto the stack. From the next cycle `depth` is one higher and `result` equals that value.
- R2: Kind code 2 (add) with at least two entries removes the top two entries and pushes their sum modulo 2^16, so `depth` drops by one.
- R3: Kind code 3 (subtract) with at least two entries pushes (deeper entry minus top entry) modulo 2^16.
- R4: Kind code 4 (multiply) with at least two entries holds `tok_ready` low for exactly the one cycle after acceptance. It then replaces the two top entries with the low 16 bits of their product.
- R5: Kind code 1 (pop) on a non-empty stack removes the top entry. `result` then shows the new top, or 0 when the stack is empty.
- R6: The stack holds 8 entries. A push onto a full stack is discarded and sets `err_overflow`, which stays set until clear or reset.
- R7: A binary operator with fewer than two entries, or a pop on an empty stack, leaves the stack unchanged and sets `err_underflow`, which stays set until clear or reset.
- R8: While `clear` is high, `tok_ready` is low and no token is taken. One cycle after `clear`, `depth` is 0 and both error flags are 0.
- R9: A token is taken only in a cycle where `tok_valid` and `tok_ready` are both high. Kind codes 5 to 7 are accepted and change nothing.
- R10: After reset, `depth` is 0, `result` is 0, both flags are 0 and `tok_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empties the stack and clears the error flags |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Block can take a token this cycle |
| tok_kind | input | 3 | Token kind: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5-7 no operation |
| tok_data | input | 16 | Operand value for a push |
| result | output | 16 | Current top of stack, 0 when empty |
| depth | output | 4 | Number of entries on the stack |
| err_underflow | output | 1 | Sticky flag: operator found too few entries |
| err_overflow | output | 1 | Sticky flag: push onto a full stack |

## Verification
The embedded properties check the following on every cycle:
- the depth bound;
- depth growth on a push;
- depth change on an underflow or a rejected push;
- the one-cycle stall after a multiply, and the fold two cycles after it;
- flag stickiness;
- the effect of clear.

The numeric results can only be shown by the bench's token sequences. These are the wrapped sums, differences and products, the operand order of subtraction, and whole expressions such as 3 4 * 5 6 * + giving 42. The same holds for the stack contents that survive underflow and overflow events.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

    typedef enum logic [2:0] {
        TK_PUSH = 3'd0,
        TK_POP  = 3'd1,
        TK_ADD  = 3'd2,
        TK_SUB  = 3'd3,
        TK_MUL  = 3'd4
    } tok_kind_e;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_FOLD = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic is_push;
        logic is_pop;
        logic is_bin;
        logic is_mul;
    } tok_class_t;

    function automatic tok_class_t classify(input logic [2:0] kind);
        tok_class_t c;
        c.is_push = (kind == TK_PUSH);
        c.is_pop  = (kind == TK_POP);
        c.is_bin  = (kind == TK_ADD) || (kind == TK_SUB) || (kind == TK_MUL);
        c.is_mul  = (kind == TK_MUL);
        return c;
    endfunction

endpackage

// File: rtl/rpn_stack.sv
module rpn_stack
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  stk_op_e       op,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  top,
    output logic [W-1:0]  second,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt_q;

    // One write port per entry: a push lands at index cnt, a fold at cnt-2.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic wr_en;
        assign wr_en = ((op == STK_PUSH) && (int'(cnt_q) == g)) ||
                       ((op == STK_FOLD) && (int'(cnt_q) == g + 2));
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && !clr) begin
                mem[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                STK_PUSH: if (int'(cnt_q) < DEPTH) cnt_q <= cnt_q + CW'(1);
                STK_POP:  if (cnt_q != '0)         cnt_q <= cnt_q - CW'(1);
                STK_FOLD: if (int'(cnt_q) >= 2)    cnt_q <= cnt_q - CW'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        top    = '0;
        second = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(cnt_q) == i + 1) top    = mem[i];
            if (int'(cnt_q) == i + 2) second = mem[i];
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/rpn_alu.sv
module rpn_alu
    import rpn_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   kind,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] sum_diff,
    output logic [W-1:0] product
);

    always_comb begin
        if (kind == TK_SUB) sum_diff = lhs - rhs;
        else                sum_diff = lhs + rhs;
    end

    assign product = lhs * rhs;

endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tok_valid,
    output logic          tok_ready,
    input  logic [2:0]    tok_kind,
    input  logic [W-1:0]  tok_data,
    output logic [W-1:0]  result,
    output logic [CW-1:0] depth,
    output logic          err_underflow,
    output logic          err_overflow
);

    tok_class_t   cls;
    logic         accept, full, two_ok, under_ev, over_ev, mul_start;
    logic         busy_q, unf_q, ovf_q;
    logic [W-1:0] mul_q, top_w, second_w, sum_diff_w, product_w, wdata;
    stk_op_e      op;

    assign cls       = classify(tok_kind);
    assign tok_ready = !busy_q && !clear;
    assign accept    = tok_valid && tok_ready;
    assign full      = (int'(depth) == DEPTH);
    assign two_ok    = (int'(depth) >= 2);
    assign under_ev  = accept && ((cls.is_bin && !two_ok) || (cls.is_pop && depth == '0));
    assign over_ev   = accept && cls.is_push && full;
    assign mul_start = accept && cls.is_mul && two_ok;

    rpn_alu #(.W(W)) i_alu (
        .kind     (tok_kind),
        .lhs      (second_w),
        .rhs      (top_w),
        .sum_diff (sum_diff_w),
        .product  (product_w)
    );

    always_comb begin
        op    = STK_IDLE;
        wdata = tok_data;
        if (busy_q) begin
            op    = STK_FOLD;
            wdata = mul_q;
        end else if (accept) begin
            if (cls.is_push && !full) begin
                op = STK_PUSH;
            end else if (cls.is_pop && depth != '0) begin
                op = STK_POP;
            end else if (cls.is_bin && !cls.is_mul && two_ok) begin
                op    = STK_FOLD;
                wdata = sum_diff_w;
            end
        end
    end

    rpn_stack #(.W(W), .DEPTH(DEPTH)) i_stack (
        .clk    (clk),
        .rst    (rst),
        .clr    (clear),
        .op     (op),
        .wdata  (wdata),
        .top    (top_w),
        .second (second_w),
        .count  (depth)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy_q <= 1'b0;
            mul_q  <= '0;
            unf_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            busy_q <= mul_start;
            if (mul_start) mul_q <= product_w;
            if (under_ev)  unf_q <= 1'b1;
            if (over_ev)   ovf_q <= 1'b1;
        end
    end

    assign result        = top_w;
    assign err_underflow = unf_q;
    assign err_overflow  = ovf_q;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(depth) <= DEPTH); // R6
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst || clear)
        (accept && cls.is_push && !full) |=> depth == $past(depth) + CW'(1)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst || clear)
        (accept && cls.is_push && full) |=> (err_overflow && $stable(depth))); // R6
    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (rst || clear)
        under_ev |=> (err_underflow && $stable(depth))); // R7
    AST_MUL_STALL: assert property (@(posedge clk) disable iff (rst || clear)
        mul_start |=> !tok_ready); // R4
    AST_MUL_FOLD: assert property (@(posedge clk) disable iff (rst || clear)
        mul_start |=> ##1 (depth == $past(depth, 2) - CW'(1))); // R4
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (depth == '0 && !err_underflow && !err_overflow)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst || clear)
        (err_overflow || err_underflow) |=>
        (err_overflow >= $past(err_overflow) && err_underflow >= $past(err_underflow))); // R7
    AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        clear |-> !tok_ready); // R8

endmodule

// File: tb/test_rpn_eval.sv
module test_rpn_eval;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear = 1'b0;
    logic        tok_valid = 1'b0;
    logic        tok_ready;
    logic [2:0]  tok_kind = 3'd0;
    logic [15:0] tok_data = 16'd0;
    logic [15:0] result;
    logic [3:0]  depth;
    logic        err_underflow, err_overflow;

    int n_chk = 0;
    int n_fail = 0;
    logic saw_stall;

    always #2 clk = ~clk;

    rpn_eval i_rpn_eval (
        .clk(clk), .rst(rst), .clear(clear),
        .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_kind(tok_kind), .tok_data(tok_data),
        .result(result), .depth(depth),
        .err_underflow(err_underflow), .err_overflow(err_overflow)
    );

    // {kind, data, expected top, expected depth}
    localparam int NV = 26;
    localparam logic [38:0] VEC [NV] = '{
        {3'd0, 16'd3,     16'd3,     4'd1},
        {3'd0, 16'd4,     16'd4,     4'd2},
        {3'd4, 16'd0,     16'd12,    4'd1},
        {3'd0, 16'd5,     16'd5,     4'd2},
        {3'd0, 16'd6,     16'd6,     4'd3},
        {3'd4, 16'd0,     16'd30,    4'd2},
        {3'd2, 16'd0,     16'd42,    4'd1},
        {3'd0, 16'd7,     16'd7,     4'd2},
        {3'd0, 16'd5,     16'd5,     4'd3},
        {3'd4, 16'd0,     16'd35,    4'd2},
        {3'd0, 16'd7,     16'd7,     4'd3},
        {3'd0, 16'd3,     16'd3,     4'd4},
        {3'd0, 16'd5,     16'd5,     4'd5},
        {3'd4, 16'd0,     16'd15,    4'd4},
        {3'd2, 16'd0,     16'd22,    4'd3},
        {3'd3, 16'd0,     16'd13,    4'd2},
        {3'd1, 16'd0,     16'd42,    4'd1},
        {3'd0, 16'd2,     16'd2,     4'd2},
        {3'd3, 16'd0,     16'd40,    4'd1},
        {3'd0, 16'd50,    16'd50,    4'd2},
        {3'd3, 16'd0,     16'hFFF6,  4'd1},
        {3'd0, 16'h8000,  16'h8000,  4'd2},
        {3'd0, 16'd4,     16'd4,     4'd3},
        {3'd4, 16'd0,     16'd0,     4'd2},
        {3'd6, 16'd9,     16'd0,     4'd2},
        {3'd2, 16'd0,     16'hFFF6,  4'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd0: return "R1";
            3'd1: return "R5";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic send_tok(input logic [2:0] k, input logic [15:0] d);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = k; tok_data = d;
        while (!tok_ready) @(negedge clk);
        @(negedge clk);
        tok_valid = 1'b0;
        saw_stall = !tok_ready;
        while (!tok_ready) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(depth == 0, "R10 depth", depth, 0);
        chk(result == 0, "R10 result", result, 0);
        chk(!err_underflow && !err_overflow, "R10 flags", {err_overflow, err_underflow}, 0);
        chk(tok_ready, "R10 ready", tok_ready, 1);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  k;
            logic [15:0] d, et;
            logic [3:0]  ed;
            {k, d, et, ed} = VEC[i];
            send_tok(k, d);
            chk(result == et, req_of(k), result, et);
            chk(depth == ed, req_of(k), depth, ed);
            chk(saw_stall == (k == 3'd4), {req_of(k), " stall"}, saw_stall, (k == 3'd4));
        end
        chk(!err_underflow && !err_overflow, "R9 no flags", {err_overflow, err_underflow}, 0);

        // R9: valid low takes nothing
        @(negedge clk); tok_kind = 3'd0; tok_data = 16'h1234;
        repeat (5) @(negedge clk);
        chk(depth == 1 && result == 16'hFFF6, "R9 valid low", depth, 1);

        // R5: pop down to empty shows 0
        send_tok(3'd1, 16'd0);
        chk(depth == 0 && result == 0, "R5 empty", result, 0);

        // R7: pop on empty, then op with one entry
        send_tok(3'd1, 16'd0);
        chk(err_underflow && depth == 0, "R7 pop empty", {err_underflow, depth}, 5'h10);
        do_clear();
        send_tok(3'd0, 16'd5);
        send_tok(3'd4, 16'd0);
        chk(!saw_stall, "R7 mul no stall", saw_stall, 0);
        chk(err_underflow, "R7 flag", err_underflow, 1);
        chk(depth == 1 && result == 5, "R7 stack kept", result, 5);
        send_tok(3'd0, 16'd6);
        chk(err_underflow, "R7 sticky", err_underflow, 1);

        // R8: clear with a push offered at the same time
        @(negedge clk); clear = 1'b1; tok_valid = 1'b1; tok_kind = 3'd0; tok_data = 16'd99;
        #0;
        chk(!tok_ready, "R8 ready low", tok_ready, 0);
        @(negedge clk); clear = 1'b0; tok_valid = 1'b0;
        chk(depth == 0 && !err_underflow && !err_overflow, "R8 cleared", depth, 0);
        chk(result == 0, "R8 no push taken", result, 0);

        // R6: fill, then overflow
        for (int j = 1; j <= 9; j++) send_tok(3'd0, 16'(j));
        chk(depth == 8, "R6 depth", depth, 8);
        chk(result == 8, "R6 discarded", result, 8);
        chk(err_overflow && !err_underflow, "R6 flag", {err_overflow, err_underflow}, 2);
        send_tok(3'd1, 16'd0);
        chk(err_overflow && result == 7, "R6 sticky", result, 7);

        // R10: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(depth == 0 && !err_overflow, "R10 after reset", depth, 0);

        finish_run();
    end

endmodule